// File: doc/BRIEF.md
# Low-Toggle Split LFSR Address Sequencer

This block produces every address of a memory exactly once per sweep, for a built-in self-test controller that runs March-style passes. The address register is divided into a narrow low part and a wide high part. Each part is a complete linear feedback shift register that also passes through the all-zero state. The low part advances on every enabled clock. The high part advances only when the low part rolls over. The effect is that of counter digits: the address order stays pseudo-random, but far fewer bits toggle than in a single full-width register.

A direction input selects whether each part applies its forward feedback or the exact inverse (the reciprocal polynomial). A sweep can therefore be replayed in precisely the opposite order. Flipping direction in the middle of a sweep makes the next address the one that came before. Two one-cycle flags accompany the address. The first marks each step of the high part. The second marks that the last address of the current direction has been reached.

With the default parameters, the 16-bit address has a 3-bit low part using x^3+x^2+1 and a 13-bit high part using x^13+x^4+x^3+x+1. Both parts reset to all ones.

Top module: `lfsr_addr_gen`

## Requirements
- R1: While rst_n is low, and after it is released with en low, addr is FFFF and done and wrap are 0.
- R2: When en is low, addr keeps its value and done and wrap stay 0, whatever dir_up is.
- R3: With dir_up=1 (forward), the addresses after reset are FFFF, FFFE, FFFD, FFFA, FFFC, FFF8, FFF9, FFFB, FFF7. Each address is reached one rising edge after an enabled cycle.
- R4: The low 3 bits change on every enabled edge. The high 13 bits change only on the edge that leaves low value 011 going forward, or low value 111 going backward. Over a full forward sweep the high part therefore steps 8192 times.
- R5: A forward sweep from reset gives 65,536 distinct addresses, 0000 among them, and returns to FFFF on the 65,536th step.
- R6: The last four addresses of a forward sweep are 7FFC, 7FF8, 7FF9, 7FFB.
- R7: With dir_up=0 (backward), each step yields the address that preceded the current one in forward order. A backward sweep from FFFF is the forward sweep reversed, and reversing mid-sweep returns to the previous address.
- R8: done is 1 for exactly one cycle, in the cycle where addr shows 7FFB after a forward step or FFFF after a backward step. It is 0 otherwise.
- R9: wrap is 1 in the cycle where addr first shows a new high part, and only then.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| en | input | 1 | Advance the address by one step on this edge |
| dir_up | input | 1 | 1 = forward order, 0 = backward order |
| addr | output | 16 | Current address (ADDR_W bits) |
| wrap | output | 1 | One-cycle flag: the high part has just stepped |
| done | output | 1 | One-cycle flag: last address of this direction reached |

## Verification
Every result is due one rising edge after the falling edge that drove en and dir_up. The new address, done and wrap all come from registers loaded on that same edge, so they appear together with no extra latency. The scoreboard driver pushes one expected item per driven cycle, and the monitor compares it 2 ns after the following rising edge. The full-length sweeps sample at each falling edge before driving, so every sample reflects exactly one completed step. The backward sweep is checked entry by entry against the recorded forward history.

// File: rtl/lfsr_addr_pkg.sv
package lfsr_addr_pkg;
  // Coefficient masks: bit j set means the x^j term is present (0 < j < width).
  // The x^0 and x^width terms are always present and are implied.
  localparam logic [2:0]  LO_TAPS_DEF = 3'b100;               // x^3+x^2+1
  localparam logic [12:0] HI_TAPS_DEF = 13'b0_0000_0001_1010; // x^13+x^4+x^3+x+1

  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } sweep_dir_e;
endpackage

// File: rtl/lfsr_section.sv
module lfsr_section #(
  parameter int unsigned     W    = 3,
  parameter logic [W-1:0]    TAPS = 3'b100
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         fwd,
  output logic [W-1:0] state,
  output logic [W-1:0] state_nxt,
  output logic         at_first,
  output logic         at_last
);
  localparam logic [W-1:0] ALL_ONES  = '1;
  localparam logic [W-1:0] LAST_VAL  = {1'b0, {(W-1){1'b1}}};

  logic         lin_f, lin_r, fb_f, fb_r;
  logic [W-1:0] succ, pred;

  // Forward: shift toward MSB, feed back at LSB; the zero-detect term
  // splices the all-zero state into the cycle.
  always_comb begin
    lin_f = state[W-1];
    for (int j = 1; j < W; j++) begin
      if (TAPS[j]) lin_f = lin_f ^ state[W-1-j];
    end
    fb_f = lin_f ^ (state[W-2:0] == '0);
    succ = {state[W-2:0], fb_f};
  end

  // Backward: exact inverse of the forward step (reciprocal feedback).
  always_comb begin
    lin_r = state[0];
    for (int j = 1; j < W; j++) begin
      if (TAPS[j]) lin_r = lin_r ^ state[W-j];
    end
    fb_r = lin_r ^ (state[W-1:1] == '0);
    pred = {fb_r, state[W-1:1]};
  end

  always_comb begin
    state_nxt = state;
    if (step) state_nxt = fwd ? succ : pred;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ALL_ONES;
    else        state <= state_nxt;
  end

  assign at_first = (state == ALL_ONES);
  assign at_last  = (state == LAST_VAL);
endmodule

// File: rtl/sweep_flags.sv
module sweep_flags #(
  parameter int unsigned       AW      = 16,
  parameter logic [AW-1:0]     FWD_END = '0,
  parameter logic [AW-1:0]     BWD_END = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          fwd,
  input  logic          hi_step,
  input  logic [AW-1:0] addr_nxt,
  output logic          done,
  output logic          wrap
);
  logic done_nxt, wrap_nxt;

  always_comb begin
    done_nxt = en && (addr_nxt == (fwd ? FWD_END : BWD_END));
    wrap_nxt = hi_step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0;
      wrap <= 1'b0;
    end else begin
      done <= done_nxt;
      wrap <= wrap_nxt;
    end
  end
endmodule

// File: rtl/lfsr_addr_gen.sv
module lfsr_addr_gen #(
  parameter int unsigned            ADDR_W  = 16,
  parameter int unsigned            LO_W    = 3,
  parameter logic [LO_W-1:0]        LO_TAPS = lfsr_addr_pkg::LO_TAPS_DEF,
  parameter logic [ADDR_W-LO_W-1:0] HI_TAPS = lfsr_addr_pkg::HI_TAPS_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              dir_up,
  output logic [ADDR_W-1:0] addr,
  output logic              wrap,
  output logic              done
);
  import lfsr_addr_pkg::*;

  localparam int unsigned       HI_W    = ADDR_W - LO_W;
  localparam logic [ADDR_W-1:0] FWD_END = {1'b0, {(HI_W-1){1'b1}}, 1'b0, {(LO_W-1){1'b1}}};
  localparam logic [ADDR_W-1:0] BWD_END = '1;

  sweep_dir_e        dir;
  logic [LO_W-1:0]   lo_q, lo_d;
  logic [HI_W-1:0]   hi_q, hi_d;
  logic              lo_first, lo_last, hi_first, hi_last;
  logic              hi_step;

  assign dir     = sweep_dir_e'(dir_up);
  // High part steps with the low part's rollover in the chosen direction.
  assign hi_step = en && ((dir == DIR_UP) ? lo_last : lo_first);

  lfsr_section #(.W(LO_W), .TAPS(LO_TAPS)) u_lo (
    .clk(clk), .rst_n(rst_n), .step(en), .fwd(dir == DIR_UP),
    .state(lo_q), .state_nxt(lo_d), .at_first(lo_first), .at_last(lo_last)
  );

  lfsr_section #(.W(HI_W), .TAPS(HI_TAPS)) u_hi (
    .clk(clk), .rst_n(rst_n), .step(hi_step), .fwd(dir == DIR_UP),
    .state(hi_q), .state_nxt(hi_d), .at_first(hi_first), .at_last(hi_last)
  );

  sweep_flags #(.AW(ADDR_W), .FWD_END(FWD_END), .BWD_END(BWD_END)) u_flags (
    .clk(clk), .rst_n(rst_n), .en(en), .fwd(dir == DIR_UP),
    .hi_step(hi_step), .addr_nxt({hi_d, lo_d}), .done(done), .wrap(wrap)
  );

  assign addr = {hi_q, lo_q};
endmodule

// File: rtl/lfsr_addr_gen_chk.sv
module lfsr_addr_gen_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned LO_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              dir_up,
  input logic [ADDR_W-1:0] addr,
  input logic              wrap,
  input logic              done
);
  localparam int unsigned       HI_W     = ADDR_W - LO_W;
  localparam logic [LO_W-1:0]   LO_LAST  = {1'b0, {(LO_W-1){1'b1}}};
  localparam logic [LO_W-1:0]   LO_FIRST = '1;
  localparam logic [ADDR_W-1:0] FWD_END  = {1'b0, {(HI_W-1){1'b1}}, 1'b0, {(LO_W-1){1'b1}}};
  localparam logic [ADDR_W-1:0] BWD_END  = '1;

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(addr) && !wrap && !done));

  assert_low_moves_R4: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (addr[LO_W-1:0] != $past(addr[LO_W-1:0])));

  assert_high_still_fwd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && dir_up && addr[LO_W-1:0] != LO_LAST) |=> $stable(addr[ADDR_W-1:LO_W]));

  assert_high_still_bwd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !dir_up && addr[LO_W-1:0] != LO_FIRST) |=> $stable(addr[ADDR_W-1:LO_W]));

  assert_done_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (addr == FWD_END || addr == BWD_END));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_wrap_high_moved_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |-> (addr[ADDR_W-1:LO_W] != $past(addr[ADDR_W-1:LO_W])));
endmodule

bind lfsr_addr_gen lfsr_addr_gen_chk #(.ADDR_W(ADDR_W), .LO_W(LO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .dir_up(dir_up),
  .addr(addr), .wrap(wrap), .done(done)
);

// File: tb/lfsr_addr_gen_test.sv
module lfsr_addr_gen_test;
  logic        clk = 1'b0;
  logic        rst_n, en, dir_up;
  logic [15:0] addr;
  logic        wrap, done;

  int checks = 0;
  int fails  = 0;

  logic [15:0] q_addr[$];
  logic        q_done[$];
  logic        q_wrap[$];
  string       q_tag[$];

  logic [15:0] hist[$];
  logic [65535:0] seen;

  always #5 clk = ~clk;

  lfsr_addr_gen uut (
    .clk(clk), .rst_n(rst_n), .en(en), .dir_up(dir_up),
    .addr(addr), .wrap(wrap), .done(done)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  // Driver: applies one cycle of stimulus and queues what must follow it.
  task automatic drive(input logic e, input logic up, input logic [15:0] a,
                       input logic d, input logic w, input string tag);
    @(negedge clk);
    en     = e;
    dir_up = up;
    q_addr.push_back(a);
    q_done.push_back(d);
    q_wrap.push_back(w);
    q_tag.push_back(tag);
  endtask

  // Monitor: compares 2 ns after the rising edge that consumed the item.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q_addr.size() > 0) begin
        string t;
        logic [15:0] ea;
        logic ed, ew;
        ea = q_addr.pop_front();
        ed = q_done.pop_front();
        ew = q_wrap.pop_front();
        t  = q_tag.pop_front();
        check({t, " addr"}, 32'(addr), 32'(ea));
        check({t, " done"}, 32'(done), 32'(ed));
        check({t, " wrap"}, 32'(wrap), 32'(ew));
      end
    end
  end

  initial begin
    #1900000;
    fails++;
    $display("FAIL watchdog run did not complete");
    summary();
    $finish;
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; en = 1'b0; dir_up = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; en = 1'b0; dir_up = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset addr", 32'(addr), 32'hFFFF);
    check("R1 reset done", 32'(done), 0);
    check("R1 reset wrap", 32'(wrap), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 released addr", 32'(addr), 32'hFFFF);

    // R3 / R4 / R9: forward start of sweep
    drive(1, 1, 16'hFFFE, 0, 0, "R3 step1");
    drive(1, 1, 16'hFFFD, 0, 0, "R3 step2");
    drive(1, 1, 16'hFFFA, 0, 0, "R3 step3");
    drive(1, 1, 16'hFFFC, 0, 0, "R3 step4");
    drive(1, 1, 16'hFFF8, 0, 0, "R3 step5");
    drive(1, 1, 16'hFFF9, 0, 0, "R3 step6");
    drive(1, 1, 16'hFFFB, 0, 0, "R4 step7");
    drive(1, 1, 16'hFFF7, 0, 1, "R9 step8 high steps");
    // R7: reverse mid-sweep, high part steps back (wrap again)
    drive(1, 0, 16'hFFFB, 0, 1, "R7 back1");
    drive(1, 0, 16'hFFF9, 0, 0, "R7 back2");
    // R2: hold with either direction
    drive(0, 0, 16'hFFF9, 0, 0, "R2 hold down");
    drive(0, 1, 16'hFFF9, 0, 0, "R2 hold up");
    repeat (3) @(negedge clk);

    // Full forward sweep: R5 R6 R8 R4
    do_reset();
    begin
      int distinct = 0, done_cnt = 0, done_at = -1, wrap_cnt = 0;
      seen = '0;
      hist.delete();
      hist.push_back(addr);
      seen[addr] = 1'b1;
      distinct = 1;
      en = 1'b1; dir_up = 1'b1;
      for (int k = 1; k <= 65536; k++) begin
        @(negedge clk);
        if (done) begin done_cnt++; done_at = k; end
        if (wrap) wrap_cnt++;
        if (k < 65536) begin
          hist.push_back(addr);
          if (!seen[addr]) distinct++;
          seen[addr] = 1'b1;
        end else begin
          en = 1'b0;
          check("R5 returns to FFFF", 32'(addr), 32'hFFFF);
        end
      end
      check("R5 distinct addresses", 32'(distinct), 65536);
      check("R5 zero address visited", 32'(seen[0]), 1);
      check("R6 fourth from last", 32'(hist[65532]), 32'h7FFC);
      check("R6 third from last", 32'(hist[65533]), 32'h7FF8);
      check("R6 second from last", 32'(hist[65534]), 32'h7FF9);
      check("R6 last", 32'(hist[65535]), 32'h7FFB);
      check("R8 forward done count", 32'(done_cnt), 1);
      check("R8 forward done position", 32'(done_at), 65535);
      check("R4 high steps per sweep", 32'(wrap_cnt), 8192);
    end

    // Full backward sweep from FFFF: R7 R8
    begin
      int mism = 0, done_cnt = 0, done_at = -1;
      logic [15:0] first_bad_a = '0, first_bad_e = '0;
      @(negedge clk);
      en = 1'b1; dir_up = 1'b0;
      for (int k = 1; k <= 65536; k++) begin
        @(negedge clk);
        if (done) begin done_cnt++; done_at = k; end
        if (addr !== hist[65536 - k]) begin
          if (mism == 0) begin first_bad_a = addr; first_bad_e = hist[65536 - k]; end
          mism++;
        end
        if (k == 65536) en = 1'b0;
      end
      check("R7 backward mirrors forward", 32'(first_bad_a), 32'(first_bad_e));
      check("R7 backward mismatch count", 32'(mism), 0);
      check("R8 backward done count", 32'(done_cnt), 1);
      check("R8 backward done position", 32'(done_at), 65536);
    end

    repeat (2) @(negedge clk);
    summary();
    $finish;
  end
endmodule